// File: doc/BRIEF.md
# Receive-Enable Delay Calibration Sequencer

This block finds the receive-enable delay for one byte lane of a DDR read path. Once it is started, it walks a delay setting made of four fields: a coarse clock count, a quarter-step medium field, a fine tap and an interpolator phase. After each change to the setting it asks an external delay stepper to apply the new value. It then asks a strobe sampler for the strobe level that the next test read captures. From the sequence of sampled levels it locates the rising strobe edge and the read preamble, and it settles on a final setting.

The search has several phases. A medium sweep first finds the low region. An edge search then climbs medium until the strobe reads high, backs off one step and creeps forward tap by tap. The preamble check adds one quarter step and descends coarse until the strobe reads low. A second edge search follows. The interpolator phase is forced to 3 after the first edge and to 7 after the second. During the search the block holds the lane's receive-enable bit high. It raises `done` on success and `fail` on any limit or stepper error.

Each sample is a four-step sequence. The probe reset is pulled low for a set number of clocks and then released for the same number of clocks. A read request is then held until the read returns the strobe bit.

Top module: `rcven_cal_seq`

## Requirements
- R1: On `start`, coarse loads `cas_lat`+1, tap and interpolator load 0, and medium loads the lane index shifted right by one (lanes 0-1 give 0, 6-7 give 3). These values are visible at the first program request.
- R2: `rcv_en` rises with the start of the search and stays high while any program or sample is in progress. It falls when `done` rises. After `fail` it stays high.
- R3: For every sample, `probe_rst_n` is low for exactly WAIT_CLKS clocks and then high for WAIT_CLKS clocks before `rd_req` rises. `rd_req` is never high together with `pgm_req`.
- R4: The first phase raises medium one step per high sample. At the first low sample it takes one further medium step.
- R5: An edge search raises medium until a high sample, lowers medium by one, then raises tap at least once and keeps raising it until a high sample. A tap step up from 14 gives tap 0 with medium carried up, and a tap step down from 0 gives tap 14 with medium borrowed. Medium carries into and borrows from coarse in the same way. Tap never exceeds 14.
- R6: After the first edge search, tap is lowered by one and the interpolator is set to 3.
- R7: The preamble check takes one medium step up and fails unless the next sample is high. It then lowers coarse by one per high sample until a low sample. It fails if coarse is 0 while the strobe still reads high.
- R8: After the second edge search, tap is lowered by one and the interpolator is set to 7. Then `done` is raised.
- R9: A `pgm_err` response to any program request ends the search with `fail` high and `done` low.
- R10: A high sample at the entry of a fine tap search sets `warn`, and the search still runs to a normal end.
- R11: A medium step up from medium 3 at coarse CRS_MAX fails the search and leaves the delay fields unchanged.
- R12: The delay fields stay stable while a program request is pending and not yet acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a calibration |
| cas_lat | input | 4 | CAS latency in clocks |
| lane | input | 3 | Byte lane index |
| pgm_req | output | 1 | Request to apply the delay fields, held until ack or error |
| pgm_ack | input | 1 | Stepper has applied the fields |
| pgm_err | input | 1 | Stepper rejected the fields |
| probe_rst_n | output | 1 | Strobe probe reset, active low |
| rd_req | output | 1 | Test read request, held until ack |
| rd_ack | input | 1 | Test read finished, strobe bit valid |
| rd_dqs | input | 1 | Captured strobe level |
| rcv_en | output | 1 | Per-lane receive-enable bit |
| done | output | 1 | Calibration finished successfully (level) |
| fail | output | 1 | Calibration aborted (level) |
| warn | output | 1 | Strobe read high at a fine-search entry |
| coarse_o | output | 4 | Coarse delay field |
| medium_o | output | 2 | Medium (quarter-step) field |
| tap_o | output | 4 | Fine tap field |
| pi_o | output | 3 | Interpolator phase field |

## Verification
On every cycle the assertions check the following:
- program and read requests never overlap;
- a read only starts with the probe released;
- the receive-enable bit covers all activity and clears at success;
- success always leaves the interpolator at 7;
- tap stays in range;
- the fields do not move under a pending program.

Only the bench scenarios can show where the search lands. This covers the exact field values after each phase, the wrap of tap into medium, the inconsistent-strobe warning, and each of the failure paths (failed preamble check, coarse exhausted, stepper error, medium overflow). These depend on the strobe pattern that the read model returns.

// File: rtl/rcven_pkg.sv
package rcven_pkg;
  localparam int CRS_W = 4;
  localparam int MED_W = 2;
  localparam int TAP_W = 4;
  localparam int PI_W  = 3;

  typedef struct packed {
    logic [CRS_W-1:0] crs;
    logic [MED_W-1:0] med;
    logic [TAP_W-1:0] tap;
    logic [PI_W-1:0]  pi;
  } dly_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_MED_UP, OP_MED_DN, OP_TAP_UP, OP_TAP_DN, OP_CRS_DN
  } op_e;

  typedef enum logic [2:0] {
    PH_LOW, PH_HI, PH_FENT, PH_FINE, PH_PRE, PH_CHK, PH_DESC, PH_END
  } ph_e;

  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_SAMP} st_e;
endpackage

// File: rtl/rcven_step.sv
module rcven_step import rcven_pkg::*; #(
  parameter int CRS_MAX = 15,
  parameter int TAP_MAX = 14
) (
  input  dly_t cur,
  input  op_e  op,
  output dly_t nxt,
  output logic err
);
  localparam logic [CRS_W-1:0] CMAX = CRS_W'(CRS_MAX);
  localparam logic [MED_W-1:0] MMAX = MED_W'((1 << MED_W) - 1);
  localparam logic [TAP_W-1:0] TMAX = TAP_W'(TAP_MAX);

  dly_t up, dn;
  logic up_err, dn_err;

  // medium step up with carry into coarse
  always_comb begin
    up = cur;
    up_err = 1'b0;
    if (cur.med != MMAX) begin
      up.med = cur.med + 1'b1;
    end else if (cur.crs != CMAX) begin
      up.med = '0;
      up.crs = cur.crs + 1'b1;
    end else begin
      up_err = 1'b1;
    end
  end

  // medium step down with borrow from coarse
  always_comb begin
    dn = cur;
    dn_err = 1'b0;
    if (cur.med != '0) begin
      dn.med = cur.med - 1'b1;
    end else if (cur.crs != '0) begin
      dn.med = MMAX;
      dn.crs = cur.crs - 1'b1;
    end else begin
      dn_err = 1'b1;
    end
  end

  always_comb begin
    nxt = cur;
    err = 1'b0;
    unique case (op)
      OP_MED_UP: begin nxt = up; err = up_err; end
      OP_MED_DN: begin nxt = dn; err = dn_err; end
      OP_TAP_UP: begin
        if (cur.tap == TMAX) begin
          nxt = up; nxt.tap = '0; err = up_err;
        end else begin
          nxt.tap = cur.tap + 1'b1;
        end
      end
      OP_TAP_DN: begin
        if (cur.tap != '0) begin
          nxt.tap = cur.tap - 1'b1;
        end else begin
          nxt = dn; nxt.tap = TMAX; err = dn_err;
        end
      end
      OP_CRS_DN: begin
        if (cur.crs != '0) nxt.crs = cur.crs - 1'b1;
        else err = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rcven_probe.sv
module rcven_probe #(
  parameter int WAIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic rd_ack,
  input  logic rd_dqs,
  output logic probe_rst_n,
  output logic rd_req,
  output logic smp_done,
  output logic smp_val
);
  localparam int CNT_W = $clog2(WAIT_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LD = CNT_W'(WAIT_CLKS - 1);

  typedef enum logic [1:0] {P_IDLE, P_RLO, P_RHI, P_RD} pst_e;
  pst_e ps;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps <= P_IDLE;
      cnt <= '0;
      probe_rst_n <= 1'b1;
      rd_req <= 1'b0;
      smp_done <= 1'b0;
      smp_val <= 1'b0;
    end else begin
      smp_done <= 1'b0;
      unique case (ps)
        P_IDLE: if (go) begin
          probe_rst_n <= 1'b0;
          cnt <= CNT_LD;
          ps <= P_RLO;
        end
        P_RLO: begin
          if (cnt == '0) begin
            probe_rst_n <= 1'b1;
            cnt <= CNT_LD;
            ps <= P_RHI;
          end else cnt <= cnt - 1'b1;
        end
        P_RHI: begin
          if (cnt == '0) begin
            rd_req <= 1'b1;
            ps <= P_RD;
          end else cnt <= cnt - 1'b1;
        end
        P_RD: if (rd_ack) begin
          rd_req <= 1'b0;
          smp_val <= rd_dqs;
          smp_done <= 1'b1;
          ps <= P_IDLE;
        end
        default: ps <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rcven_cal_seq.sv
module rcven_cal_seq import rcven_pkg::*; #(
  parameter int CRS_MAX   = 15,
  parameter int TAP_MAX   = 14,
  parameter int LANES     = 8,
  parameter int WAIT_CLKS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [CRS_W-1:0]            cas_lat,
  input  logic [$clog2(LANES)-1:0]    lane,
  output logic                        pgm_req,
  input  logic                        pgm_ack,
  input  logic                        pgm_err,
  output logic                        probe_rst_n,
  output logic                        rd_req,
  input  logic                        rd_ack,
  input  logic                        rd_dqs,
  output logic                        rcv_en,
  output logic                        done,
  output logic                        fail,
  output logic                        warn,
  output logic [CRS_W-1:0]            coarse_o,
  output logic [MED_W-1:0]            medium_o,
  output logic [TAP_W-1:0]            tap_o,
  output logic [PI_W-1:0]             pi_o
);
  localparam int LANE_W = $clog2(LANES);
  localparam logic [PI_W-1:0] PI_FIRST  = PI_W'(3);
  localparam logic [PI_W-1:0] PI_SECOND = PI_W'(7);

  st_e  st;
  ph_e  ph;
  dly_t dly, step_nxt;
  op_e  op;
  logic step_err, second, smp_go, smp_done, smp_val;

  rcven_step #(.CRS_MAX(CRS_MAX), .TAP_MAX(TAP_MAX)) u_step (
    .cur(dly), .op(op), .nxt(step_nxt), .err(step_err)
  );

  rcven_probe #(.WAIT_CLKS(WAIT_CLKS)) u_probe (
    .clk(clk), .rst(rst), .go(smp_go), .rd_ack(rd_ack), .rd_dqs(rd_dqs),
    .probe_rst_n(probe_rst_n), .rd_req(rd_req),
    .smp_done(smp_done), .smp_val(smp_val)
  );

  // which delay move the current event asks for
  always_comb begin
    op = OP_NONE;
    if (st == ST_PROG && pgm_ack && !pgm_err && ph == PH_PRE) op = OP_MED_UP;
    if (st == ST_SAMP && smp_done) begin
      unique case (ph)
        PH_LOW:  op = OP_MED_UP;
        PH_HI:   op = smp_val ? OP_MED_DN : OP_MED_UP;
        PH_FENT: op = OP_TAP_UP;
        PH_FINE: op = smp_val ? OP_TAP_DN : OP_TAP_UP;
        PH_DESC: op = smp_val ? OP_CRS_DN : OP_NONE;
        default: op = OP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      ph <= PH_LOW;
      dly <= '0;
      second <= 1'b0;
      rcv_en <= 1'b0;
      done <= 1'b0;
      fail <= 1'b0;
      warn <= 1'b0;
      pgm_req <= 1'b0;
      smp_go <= 1'b0;
    end else begin
      smp_go <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          dly.crs <= cas_lat + 1'b1;
          dly.med <= lane[LANE_W-1 -: MED_W];
          dly.tap <= '0;
          dly.pi <= '0;
          ph <= PH_LOW;
          second <= 1'b0;
          rcv_en <= 1'b1;
          done <= 1'b0;
          fail <= 1'b0;
          warn <= 1'b0;
          pgm_req <= 1'b1;
          st <= ST_PROG;
        end
        ST_PROG: begin
          if (pgm_err) begin
            pgm_req <= 1'b0;
            fail <= 1'b1;
            st <= ST_IDLE;
          end else if (pgm_ack) begin
            pgm_req <= 1'b0;
            if (ph == PH_PRE) begin
              if (step_err) begin
                fail <= 1'b1;
                st <= ST_IDLE;
              end else begin
                dly <= step_nxt;
                ph <= PH_CHK;
                pgm_req <= 1'b1;
              end
            end else if (ph == PH_END) begin
              done <= 1'b1;
              rcv_en <= 1'b0;
              st <= ST_IDLE;
            end else begin
              smp_go <= 1'b1;
              st <= ST_SAMP;
            end
          end
        end
        ST_SAMP: if (smp_done) begin
          if (op != OP_NONE && step_err) begin
            fail <= 1'b1;
            st <= ST_IDLE;
          end else begin
            dly <= step_nxt;
            pgm_req <= 1'b1;
            st <= ST_PROG;
            unique case (ph)
              PH_LOW:  if (!smp_val) ph <= PH_HI;
              PH_HI:   if (smp_val) ph <= PH_FENT;
              PH_FENT: begin
                if (smp_val) warn <= 1'b1;
                ph <= PH_FINE;
              end
              PH_FINE: if (smp_val) begin
                dly.pi <= second ? PI_SECOND : PI_FIRST;
                ph <= second ? PH_END : PH_PRE;
              end
              PH_CHK: begin
                pgm_req <= 1'b0;
                if (smp_val) begin
                  ph <= PH_DESC;
                  smp_go <= 1'b1;
                  st <= ST_SAMP;
                end else begin
                  fail <= 1'b1;
                  st <= ST_IDLE;
                end
              end
              PH_DESC: if (!smp_val) begin
                pgm_req <= 1'b0;
                second <= 1'b1;
                ph <= PH_HI;
                smp_go <= 1'b1;
                st <= ST_SAMP;
              end
              default: ;
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign coarse_o = dly.crs;
  assign medium_o = dly.med;
  assign tap_o    = dly.tap;
  assign pi_o     = dly.pi;
endmodule

// File: rtl/rcven_cal_chk.sv
module rcven_cal_chk #(
  parameter int TAP_MAX = 14
) (
  input logic       clk,
  input logic       rst,
  input logic       pgm_req,
  input logic       pgm_ack,
  input logic       rd_req,
  input logic       probe_rst_n,
  input logic       rcv_en,
  input logic       done,
  input logic       fail,
  input logic [3:0] coarse_o,
  input logic [1:0] medium_o,
  input logic [3:0] tap_o,
  input logic [2:0] pi_o
);
  p_req_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(pgm_req && rd_req));

  p_read_after_release_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> (probe_rst_n && $past(probe_rst_n)));

  p_en_covers_activity_r2: assert property (@(posedge clk) disable iff (rst)
    (pgm_req || rd_req || !probe_rst_n) |-> rcv_en);

  p_en_cleared_at_done_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !rcv_en);

  p_final_phase_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (pi_o == 3'd7));

  p_single_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  p_tap_range_r5: assert property (@(posedge clk) disable iff (rst)
    int'(tap_o) <= TAP_MAX);

  p_fields_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (pgm_req && $past(pgm_req) && !$past(pgm_ack)) |->
      $stable({coarse_o, medium_o, tap_o, pi_o}));
endmodule

bind rcven_cal_seq rcven_cal_chk #(.TAP_MAX(TAP_MAX)) u_chk (
  .clk(clk), .rst(rst), .pgm_req(pgm_req), .pgm_ack(pgm_ack),
  .rd_req(rd_req), .probe_rst_n(probe_rst_n), .rcv_en(rcv_en),
  .done(done), .fail(fail), .coarse_o(coarse_o), .medium_o(medium_o),
  .tap_o(tap_o), .pi_o(pi_o)
);

// File: tb/tb_rcven_cal_seq.sv
module tb_rcven_cal_seq;
  localparam int WAITC = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [3:0] cas = '0;
  logic [2:0] lane = '0;
  logic pgm_ack = 1'b0, pgm_err = 1'b0, rd_ack = 1'b0, rd_dqs = 1'b0;
  logic pgm_req, probe_rst_n, rd_req, rcv_en, done, fail, warn;
  logic [3:0] coarse_o, tap_o;
  logic [1:0] medium_o;
  logic [2:0] pi_o;

  int nchk = 0, nbad = 0;
  int lo_edge = 0, hi_edge = 0, force_rd = 0, force_val = 0, err_at = 0;
  int rd_cnt = 0, pg_cnt = 0, model_f = 0;
  int prog_f [0:63];
  int first_c = 0, first_m = 0, first_t = 0, first_p = 0;
  int p3_f = -1;
  int lo_run = 0, hi_run = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0, prev_rst = 1'b1, prev_rd = 1'b0;
  logic [12:0] prev_fields = '0;
  bit finished = 0;

  rcven_cal_seq #(.WAIT_CLKS(WAITC)) dut (
    .clk(clk), .rst(rst), .start(start), .cas_lat(cas), .lane(lane),
    .pgm_req(pgm_req), .pgm_ack(pgm_ack), .pgm_err(pgm_err),
    .probe_rst_n(probe_rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_dqs(rd_dqs), .rcv_en(rcv_en), .done(done), .fail(fail),
    .warn(warn), .coarse_o(coarse_o), .medium_o(medium_o),
    .tap_o(tap_o), .pi_o(pi_o)
  );

  always #2.5 clk = ~clk;

  function automatic int pos(input int c, input int m, input int t);
    return (c * 4 + m) * 15 + t;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitors and responders, all at the falling edge
  always @(negedge clk) begin
    if (!rst && pgm_req && prev_req && !prev_ack &&
        {coarse_o, medium_o, tap_o, pi_o} != prev_fields)
      chk("R12 fields moved under pending program", 1, 0);
    if (!probe_rst_n) begin
      lo_run = prev_rst ? 1 : lo_run + 1;
      hi_run = 0;
    end else if (!rd_req) hi_run++;
    if (!rst && rd_req && !prev_rd) begin
      chk("R3 probe low clocks", lo_run, WAITC);
      chk("R3 probe high clocks", hi_run, WAITC);
    end
    if (pgm_req && !pgm_ack && !pgm_err) begin
      pg_cnt++;
      if (pg_cnt == err_at) pgm_err = 1'b1;
      else begin
        pgm_ack = 1'b1;
        model_f = pos(coarse_o, medium_o, tap_o);
        if (pg_cnt < 64) prog_f[pg_cnt] = model_f;
        if (pg_cnt == 1) begin
          first_c = coarse_o; first_m = medium_o;
          first_t = tap_o; first_p = pi_o;
        end
        if (pi_o == 3'd3 && p3_f < 0) p3_f = model_f;
      end
    end else begin
      pgm_ack = 1'b0;
      pgm_err = 1'b0;
    end
    if (rd_req && !rd_ack) begin
      rd_cnt++;
      if (rd_cnt == force_rd) rd_dqs = force_val[0];
      else rd_dqs = (model_f < lo_edge) || (model_f >= hi_edge);
      rd_ack = 1'b1;
    end else rd_ack = 1'b0;
    prev_req = pgm_req;
    prev_ack = pgm_ack;
    prev_rst = probe_rst_n;
    prev_rd = rd_req;
    prev_fields = {coarse_o, medium_o, tap_o, pi_o};
  end

  task automatic run_cal(input int c, input int l, input int lo, input int hi,
                         input int frd, input int fval, input int eat);
    cas = c[3:0]; lane = l[2:0];
    lo_edge = lo; hi_edge = hi; force_rd = frd; force_val = fval; err_at = eat;
    rd_cnt = 0; pg_cnt = 0; p3_f = -1;
    for (int i = 0; i < 64; i++) prog_f[i] = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 receive enable raised at start", rcv_en, 1);
    for (int i = 0; i < 20000 && !(done || fail); i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 reset done", done, 0);
    chk("R2 reset fail", fail, 0);
    chk("R2 reset rcv_en", rcv_en, 0);
    chk("R3 reset probe released", probe_rst_n, 1);
    chk("R3 reset no read", rd_req, 0);
  endtask

  task automatic t_nominal;
    run_cal(4, 0, 330, 380, 0, 0, 0);
    chk("R1 init coarse", first_c, 5);
    chk("R1 init medium lane0", first_m, 0);
    chk("R1 init tap", first_t, 0);
    chk("R1 init pi", first_p, 0);
    chk("R4 extra medium step after low", prog_f[4], 345);
    chk("R5 medium backed off", prog_f[8], 375);
    chk("R5 first tap step", prog_f[9], 376);
    chk("R6 tap minus one with pi 3", p3_f, 379);
    chk("R7 coarse descent", prog_f[16], 334);
    chk("R8 done", done, 1);
    chk("R8 no fail", fail, 0);
    chk("R8 coarse", coarse_o, 6);
    chk("R8 medium", medium_o, 1);
    chk("R8 tap", tap_o, 4);
    chk("R8 pi", pi_o, 7);
    chk("R2 rcv_en cleared", rcv_en, 0);
    chk("R10 no warning", warn, 0);
  endtask

  task automatic t_warn_wrap;
    run_cal(2, 6, 240, 300, 7, 1, 0);
    chk("R1 init coarse", first_c, 3);
    chk("R1 init medium lane6", first_m, 3);
    chk("R10 warning set", warn, 1);
    chk("R10 search finished", done, 1);
    chk("R5 wrap coarse", coarse_o, 4);
    chk("R5 wrap medium", medium_o, 3);
    chk("R5 wrap tap", tap_o, 14);
    chk("R8 pi", pi_o, 7);
  endtask

  task automatic t_pre_fail;
    run_cal(4, 0, 330, 380, 14, 0, 0);
    chk("R7 preamble low fails", fail, 1);
    chk("R7 no done", done, 0);
    chk("R2 rcv_en kept on fail", rcv_en, 1);
  endtask

  task automatic t_desc_fail;
    run_cal(0, 0, 75, 120, 0, 0, 0);
    chk("R7 coarse exhausted fails", fail, 1);
    chk("R7 coarse at zero", coarse_o, 0);
  endtask

  task automatic t_step_err;
    run_cal(4, 0, 330, 380, 0, 0, 3);
    chk("R9 stepper error fails", fail, 1);
    chk("R9 no done", done, 0);
  endtask

  task automatic t_med_ovf;
    run_cal(14, 7, 1000, 1000, 0, 0, 0);
    chk("R11 overflow fails", fail, 1);
    chk("R11 coarse unchanged", coarse_o, 15);
    chk("R11 medium unchanged", medium_o, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_warn_wrap();
    t_pre_fail();
    t_desc_fail();
    t_step_err();
    t_med_ovf();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule